// File: doc/BRIEF.md
# Dual-Channel Serial Pattern Generator

This block drives two independent serial outputs. Each output is a pair of wires: a data line and a clock line. A channel is given a pattern of up to 64 bits, a bit count, a repeat count, a divider value and a clock polarity. When it is started, it shifts the pattern out least significant bit first and repeats the whole pattern the programmed number of times. Its output clock runs at the system clock divided by a programmable amount.

Each channel is built from three cascaded counters. A divider counter produces the output clock phases. A bit counter walks through the pattern and advances once per output clock period. A repetition counter advances only when the bit counter wraps. Each counter returns to zero after it matches its programmed limit. When the repetition counter matches its limit at the moment the bit counter wraps, the channel stops and reports completion.

Configuration arrives on plain input ports and is captured when a start is accepted. Software access and interrupt masking sit outside this block.

Top module: `dual_pattern_tx`

## Requirements
- R1: After reset and while idle, each data line is 0, each clock line equals that channel's polarity input, and the done and interrupt outputs are 0.
- R2: While a channel is running, each phase of its output clock lasts P+1 system cycles, where P is the divider value captured at start. One bit therefore occupies 2·(P+1) cycles.
- R3: A length value of L sends pattern bits 0 to L in rising index order. The data line changes only when the clock returns to its idle level, so it is stable at every active edge. The active edge is the clock leaving its idle level: rising for polarity 0, falling for polarity 1.
- R4: A repeat value of R sends the L+1 bits R+1 times, which gives (L+1)·(R+1) active edges in total.
- R5: The done output is high for exactly one cycle, 2·(P+1)·(L+1)·(R+1) clock edges after the edge that accepts the start. In that cycle the channel is already idle: data is 0 and the clock is at its idle level.
- R6: The interrupt output rises together with done. It stays high until the next accepted start or until the enable is cleared, and it is low in the cycle after an accepted start.
- R7: Clearing the enable stops the channel at the next edge. All counters return to zero, the outputs go idle, the interrupt is cleared and no done follows. A start while the enable is low is ignored.
- R8: Pattern, divider, length and repeat values are captured at start. Changing these inputs during a transfer does not alter the bits sent or the completion time.
- R9: A start pulse while the channel is running is ignored and does not alter the completion time.
- R10: The channels are independent. A transfer on one channel produces no done on the other, and two channels started in the same cycle with the same settings finish in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ena_i | input | NUM_CH | Per-channel enable; low aborts and holds the channel idle |
| start_i | input | NUM_CH | Per-channel start request, accepted when enabled and idle |
| pol_i | input | NUM_CH | Clock idle level (0: idle low, rising active edge; 1: idle high, falling active edge) |
| pattern_i | input | NUM_CH×64 | Bit pattern, sent from bit 0 upward |
| prediv_i | input | NUM_CH×32 | Divider value P; each clock phase lasts P+1 cycles |
| len_i | input | NUM_CH×6 | Length value L; L+1 bits are sent per pass |
| reps_i | input | NUM_CH×10 | Repeat value R; R+1 passes are sent |
| sda_o | output | NUM_CH | Serial data lines |
| scl_o | output | NUM_CH | Serial clock lines |
| done_o | output | NUM_CH | One-cycle completion pulse |
| irq_o | output | NUM_CH | Completion interrupt level |

## Verification
Three events can land on the same clock edge: the bit counter wraps, the repetition counter matches its limit, and the last divided-clock phase toggles. Together they stop the transfer, raise done and return the clock to idle. The bench provokes this with single-bit patterns, patterns of the full 64 bits and the largest repeat count. It judges the outcome by the exact edge count to done, the number of active edges, and the idle levels seen in the done cycle itself.

A second case starts both channels with identical settings in one cycle and requires both done outputs to be high in the same sampled cycle.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

    localparam int unsigned PAT_W = 64;
    localparam int unsigned DIV_W = 32;
    localparam int unsigned REP_W = 10;
    localparam int unsigned LEN_W = $clog2(PAT_W);

    // divider state: count of system clocks and current output clock phase
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             phase;
    } div_st_t;

    // channel state: run flag, counters, outputs and the captured settings
    typedef struct packed {
        logic             busy;
        logic [LEN_W-1:0] bit_idx;
        logic [REP_W-1:0] rep_idx;
        logic             sda;
        logic             done;
        logic             irq;
        logic             pol;
        logic [PAT_W-1:0] pat;
        logic [LEN_W-1:0] len;
        logic [REP_W-1:0] reps;
        logic [DIV_W-1:0] div;
    } ch_st_t;

endpackage

// File: rtl/dpt_clkdiv.sv
module dpt_clkdiv
    import dpt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] limit_i,
    output logic             tick_o,
    output logic             phase_o
);

    div_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d = st_q;
        hit  = run_i && (st_q.cnt == limit_i);
        if (!run_i) begin
            st_d = '0;
        end else if (hit) begin
            st_d.cnt   = '0;
            st_d.phase = ~st_q.phase;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o  = hit;
    assign phase_o = st_q.phase;

endmodule

// File: rtl/dpt_step.sv
// Bit and repetition counter cascade: next values and the final-bit flag.
module dpt_step
    import dpt_pkg::*;
(
    input  logic             adv_i,
    input  logic [LEN_W-1:0] bit_i,
    input  logic [REP_W-1:0] rep_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [REP_W-1:0] reps_i,
    output logic [LEN_W-1:0] bit_o,
    output logic [REP_W-1:0] rep_o,
    output logic             last_o
);

    logic bit_wrap;
    logic rep_en;
    logic rep_wrap;

    always_comb begin
        bit_wrap = (bit_i == len_i);
        rep_en   = adv_i && bit_wrap;
        rep_wrap = (rep_i == reps_i);

        if (!adv_i) begin
            bit_o = bit_i;
        end else if (bit_wrap) begin
            bit_o = '0;
        end else begin
            bit_o = bit_i + 1'b1;
        end

        if (!rep_en) begin
            rep_o = rep_i;
        end else if (rep_wrap) begin
            rep_o = '0;
        end else begin
            rep_o = rep_i + 1'b1;
        end

        last_o = rep_en && rep_wrap;
    end

endmodule

// File: rtl/dpt_channel.sv
module dpt_channel
    import dpt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ena_i,
    input  logic             start_i,
    input  logic             pol_i,
    input  logic [PAT_W-1:0] pat_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [REP_W-1:0] reps_i,
    output logic             sda_o,
    output logic             scl_o,
    output logic             done_o,
    output logic             irq_o
);

    ch_st_t           st_d, st_q;
    logic             tick;
    logic             phase;
    logic             adv;
    logic [LEN_W-1:0] bit_nxt;
    logic [REP_W-1:0] rep_nxt;
    logic             last;

    dpt_clkdiv u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (st_q.busy),
        .limit_i (st_q.div),
        .tick_o  (tick),
        .phase_o (phase)
    );

    // a bit ends when the divided clock returns to its idle phase
    assign adv = st_q.busy && tick && phase;

    dpt_step u_step (
        .adv_i  (adv),
        .bit_i  (st_q.bit_idx),
        .rep_i  (st_q.rep_idx),
        .len_i  (st_q.len),
        .reps_i (st_q.reps),
        .bit_o  (bit_nxt),
        .rep_o  (rep_nxt),
        .last_o (last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!ena_i) begin
            st_d = '0;
        end else if (start_i && !st_q.busy) begin
            st_d.busy    = 1'b1;
            st_d.bit_idx = '0;
            st_d.rep_idx = '0;
            st_d.pat     = pat_i;
            st_d.div     = div_i;
            st_d.len     = len_i;
            st_d.reps    = reps_i;
            st_d.pol     = pol_i;
            st_d.sda     = pat_i[0];
            st_d.irq     = 1'b0;
        end else if (adv) begin
            st_d.bit_idx = bit_nxt;
            st_d.rep_idx = rep_nxt;
            if (last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.irq  = 1'b1;
                st_d.sda  = 1'b0;
            end else begin
                st_d.sda = st_q.pat[bit_nxt];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_o  = st_q.sda;
    assign scl_o  = st_q.busy ? (phase ^ st_q.pol) : pol_i;
    assign done_o = st_q.done;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/dual_pattern_tx.sv
module dual_pattern_tx
    import dpt_pkg::*;
#(
    parameter int unsigned NUM_CH = 2
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NUM_CH-1:0]             ena_i,
    input  logic [NUM_CH-1:0]             start_i,
    input  logic [NUM_CH-1:0]             pol_i,
    input  logic [NUM_CH-1:0][PAT_W-1:0]  pattern_i,
    input  logic [NUM_CH-1:0][DIV_W-1:0]  prediv_i,
    input  logic [NUM_CH-1:0][LEN_W-1:0]  len_i,
    input  logic [NUM_CH-1:0][REP_W-1:0]  reps_i,
    output logic [NUM_CH-1:0]             sda_o,
    output logic [NUM_CH-1:0]             scl_o,
    output logic [NUM_CH-1:0]             done_o,
    output logic [NUM_CH-1:0]             irq_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dpt_channel u_ch (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .ena_i   (ena_i[c]),
            .start_i (start_i[c]),
            .pol_i   (pol_i[c]),
            .pat_i   (pattern_i[c]),
            .div_i   (prediv_i[c]),
            .len_i   (len_i[c]),
            .reps_i  (reps_i[c]),
            .sda_o   (sda_o[c]),
            .scl_o   (scl_o[c]),
            .done_o  (done_o[c]),
            .irq_o   (irq_o[c])
        );
    end

endmodule

// File: rtl/dual_pattern_tx_chk.sv
module dual_pattern_tx_chk #(
    parameter int unsigned NUM_CH = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NUM_CH-1:0] ena_i,
    input logic [NUM_CH-1:0] start_i,
    input logic [NUM_CH-1:0] pol_i,
    input logic [NUM_CH-1:0] sda_o,
    input logic [NUM_CH-1:0] scl_o,
    input logic [NUM_CH-1:0] done_o,
    input logic [NUM_CH-1:0] irq_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R5: completion is a single-cycle pulse
        a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
            done_o[c] |=> !done_o[c]);

        // R5: channel is idle in the done cycle
        a_r5_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
            done_o[c] |-> (!sda_o[c] && (scl_o[c] == pol_i[c])));

        // R6: interrupt accompanies done
        a_r6_irq_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
            done_o[c] |-> irq_o[c]);

        // R6: interrupt holds while enabled and not restarted
        a_r6_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (irq_o[c] && ena_i[c] && !start_i[c]) |=> irq_o[c]);

        // R7: disabling clears everything at the next edge
        a_r7_disable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !ena_i[c] |=> (!done_o[c] && !irq_o[c] && !sda_o[c]));
    end

endmodule

bind dual_pattern_tx dual_pattern_tx_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ena_i   (ena_i),
    .start_i (start_i),
    .pol_i   (pol_i),
    .sda_o   (sda_o),
    .scl_o   (scl_o),
    .done_o  (done_o),
    .irq_o   (irq_o)
);

// File: tb/sim_dual_pattern_tx.sv
module sim_dual_pattern_tx;

    typedef struct packed {
        logic [63:0] pat;
        logic [31:0] div;
        logic [5:0]  len;
        logic [9:0]  reps;
        logic        pol;
        logic [31:0] n;
    } vec_t;

    // n = 2*(div+1)*(len+1)*(reps+1), edges from the start edge to done
    localparam vec_t VECS [6] = '{
        '{64'h0000_0000_0000_00A5, 32'd0, 6'd7,  10'd0,    1'b0, 32'd16},
        '{64'h1234_5678_9ABC_DEF0, 32'd1, 6'd15, 10'd1,    1'b1, 32'd128},
        '{64'h8000_0000_0000_0001, 32'd0, 6'd63, 10'd1,    1'b0, 32'd256},
        '{64'h0000_0000_0000_0001, 32'd2, 6'd0,  10'd2,    1'b0, 32'd18},
        '{64'hFFFF_FFFF_FFFF_FFFE, 32'd0, 6'd0,  10'd1023, 1'b1, 32'd2048},
        '{64'hDEAD_BEEF_0BAD_F00D, 32'd3, 6'd35, 10'd0,    1'b1, 32'd288}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       ena = 2'b00;
    logic [1:0]       start = 2'b00;
    logic [1:0]       pol = 2'b10;
    logic [1:0][63:0] pat = '0;
    logic [1:0][31:0] div = '0;
    logic [1:0][5:0]  len_r = '0;
    logic [1:0][9:0]  reps_r = '0;
    logic [1:0]       sda, scl, done, irq;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    dual_pattern_tx u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .ena_i     (ena),
        .start_i   (start),
        .pol_i     (pol),
        .pattern_i (pat),
        .prediv_i  (div),
        .len_i     (len_r),
        .reps_i    (reps_r),
        .sda_o     (sda),
        .scl_o     (scl),
        .done_o    (done),
        .irq_o     (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // mode 0: plain, 1: settings change mid-run, 2: start pulse mid-run
    task automatic run_vec(input int ch, input vec_t v, input int mode, input string tag);
        int   k;
        int   edges;
        int   bad;
        int   first_t;
        int   second_t;
        int   other_done;
        logic prev;
        @(negedge clk);
        pat[ch] = v.pat; div[ch] = v.div; len_r[ch] = v.len;
        reps_r[ch] = v.reps; pol[ch] = v.pol; start[ch] = 1'b1;
        @(negedge clk);
        start[ch] = 1'b0;
        k = 1;
        check("R6", {tag, " irq low after start"}, 64'(irq[ch]), 64'd0);
        prev = v.pol; edges = 0; bad = 0; first_t = -1; second_t = -1; other_done = 0;
        while (!done[ch] && k < 6000) begin
            if (scl[ch] !== prev) begin
                if (first_t < 0) first_t = k;
                else if (second_t < 0) second_t = k;
                if (scl[ch] !== v.pol) begin
                    if (sda[ch] !== v.pat[edges % (int'(v.len) + 1)]) bad++;
                    edges++;
                end
                prev = scl[ch];
            end
            if (done[1-ch]) other_done++;
            if (mode == 1 && k == 5) begin
                pat[ch] = ~v.pat; div[ch] = v.div + 32'd5;
                len_r[ch] = v.len ^ 6'h3; reps_r[ch] = v.reps + 10'd3;
            end
            if (mode == 2 && k == 7) start[ch] = 1'b1;
            if (mode == 2 && k == 8) start[ch] = 1'b0;
            @(negedge clk);
            k++;
        end
        check(mode == 1 ? "R8" : (mode == 2 ? "R9" : "R5"), {tag, " edges to done"},
              64'(k), 64'(v.n + 1));
        check("R4", {tag, " active edges"}, 64'(edges),
              64'((int'(v.len) + 1) * (int'(v.reps) + 1)));
        check("R3", {tag, " bit mismatches"}, 64'(bad), 64'd0);
        check("R2", {tag, " half period"}, 64'(second_t - first_t), 64'(v.div + 1));
        check("R6", {tag, " irq with done"}, 64'(irq[ch]), 64'd1);
        check("R5", {tag, " idle clock at done"}, 64'(scl[ch]), 64'(v.pol));
        check("R5", {tag, " idle data at done"}, 64'(sda[ch]), 64'd0);
        check("R10", {tag, " other channel done"}, 64'(other_done), 64'd0);
        @(negedge clk);
        check("R5", {tag, " done one cycle"}, 64'(done[ch]), 64'd0);
        check("R6", {tag, " irq held"}, 64'(irq[ch]), 64'd1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                nchk++;
                nfail++;
                $display("FAIL watchdog: actual %0d expected below 150000", cyc);
                $display("%0d/%0d checks passed", nchk - nfail, nchk);
                $finish;
            end
        end
    end

    initial begin
        int k;
        int dcount;
        // R1: reset and idle levels
        repeat (3) @(negedge clk);
        check("R1", "scl in reset", 64'(scl), 64'h2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "sda idle", 64'(sda), 64'd0);
        check("R1", "scl idle", 64'(scl), 64'h2);
        check("R1", "done idle", 64'(done), 64'd0);
        check("R1", "irq idle", 64'(irq), 64'd0);

        // R7: start ignored while disabled
        pat[0] = 64'hFF; len_r[0] = 6'd3; pol[0] = 1'b0; start[0] = 1'b1;
        @(negedge clk);
        start[0] = 1'b0;
        dcount = 0;
        for (int i = 0; i < 40; i++) begin
            if (scl[0] !== 1'b0 || sda[0] !== 1'b0 || done[0]) dcount++;
            @(negedge clk);
        end
        check("R7", "activity while disabled", 64'(dcount), 64'd0);

        ena = 2'b11;
        @(negedge clk);

        // table walk over both channels
        for (int i = 0; i < 6; i++) begin
            run_vec(i % 2, VECS[i], 0, $sformatf("vec%0d", i));
        end

        // R8: settings changed mid-transfer
        run_vec(0, '{64'h0000_0000_0000_0F0F, 32'd1, 6'd11, 10'd2, 1'b0, 32'd144}, 1, "r8_change");
        // R9: start pulse mid-transfer
        run_vec(1, '{64'h0000_0000_0000_003C, 32'd0, 6'd5, 10'd3, 1'b1, 32'd48}, 2, "r9_restart");

        // R10: both channels in lockstep
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            pat[c] = 64'h5; div[c] = 32'd1; len_r[c] = 6'd3; reps_r[c] = 10'd1; pol[c] = 1'b0;
        end
        start = 2'b11;
        @(negedge clk);
        start = 2'b00;
        k = 1;
        while (done == 2'b00 && k < 200) begin
            @(negedge clk);
            k++;
        end
        check("R10", "both done together", 64'(done), 64'h3);
        check("R10", "lockstep edges", 64'(k), 64'd33);

        // R7: abort mid-transfer
        @(negedge clk);
        pat[0] = 64'hFFFF; div[0] = 32'd2; len_r[0] = 6'd15; reps_r[0] = 10'd4; pol[0] = 1'b1;
        start[0] = 1'b1;
        @(negedge clk);
        start[0] = 1'b0;
        repeat (20) @(negedge clk);
        ena[0] = 1'b0;
        @(negedge clk);
        check("R7", "sda after abort", 64'(sda[0]), 64'd0);
        check("R7", "scl after abort", 64'(scl[0]), 64'd1);
        check("R7", "irq after abort", 64'(irq[0]), 64'd0);
        dcount = 0;
        for (int i = 0; i < 600; i++) begin
            if (done[0]) dcount++;
            @(negedge clk);
        end
        check("R7", "no done after abort", 64'(dcount), 64'd0);
        ena[0] = 1'b1;
        run_vec(0, VECS[0], 0, "after_abort");

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule